// File: doc/BRIEF.md
# Crosspoint Output Arbiter

This block sits at one output column of a buffered crossbar. Each of the N crosspoint buffers that feed the output reports two things: a flag that says it holds at least one fragment, and a count of how many fragments it holds. In every internal slot the arbiter picks at most one of these buffers to send a fragment to the output. It drives a one-hot read grant and a valid strobe for that choice.

There are two selection policies. The longest-occupancy policy picks the buffer that holds the most fragments. When several buffers tie for the most, the choice among them comes from a pseudo-random rotation of the search order. The rotating policy keeps a pointer and picks the first flagged buffer at or after it. The arbiter is work-conserving: if any buffer is flagged, a grant is issued.

The policy is held in a small two-state machine. The states are `POL_LONGEST` and `POL_ROTATE`. The transition `TO_ROTATE` is taken at a clock edge when `mode_i` is 1, and the transition `TO_LONGEST` is taken at a clock edge when `mode_i` is 0. Every clock cycle is one internal slot. The grant is registered.

Top module: `xbar_out_arbiter`

## Requirements
- R1: After reset, `gnt_o` is 0, `vld_o` is 0, the policy state is `POL_LONGEST` and the rotating pointer is 0.
- R2: The grant and valid that appear after a clock edge are computed from the `nonempty_i` and `occ_i` values sampled at that edge. They are held until the next edge.
- R3: `gnt_o` has at most one bit set, and `vld_o` is 1 exactly when `gnt_o` is non-zero.
- R4: If any bit of `nonempty_i` is 1 at an edge, `vld_o` is 1 after that edge. If all bits are 0, `vld_o` is 0 after that edge.
- R5: A grant goes only to an index whose `nonempty_i` bit was 1. The occupancy of an unflagged buffer never affects the choice.
- R6: In `POL_LONGEST`, the granted index has the largest occupancy among the flagged buffers. Buffer i's occupancy is `occ_i[i*OCC_W +: OCC_W]`, an unsigned value.
- R7: In `POL_LONGEST`, ties for the largest occupancy are broken by a pseudo-random rotation that changes from slot to slot. With four tied buffers held steady for 64 slots, at least two different indices are granted.
- R8: In `POL_ROTATE`, the grant goes to the first flagged index at or after the pointer, searching in ascending index order and wrapping from N-1 to 0.
- R9: Whenever a grant is issued, in either policy, the pointer becomes the granted index plus one, wrapping N-1 to 0. A slot with no grant leaves the pointer unchanged.
- R10: `mode_i` (0 = longest-occupancy, 1 = rotating) is sampled at each edge into the policy state. A decision made at an edge uses the state loaded at the previous edge, so a change of `mode_i` takes effect one slot later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock; one internal slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | Policy request: 0 longest-occupancy, 1 rotating |
| nonempty_i | input | N | Bit i set when crosspoint buffer i holds a fragment |
| occ_i | input | N*OCC_W | Packed occupancy counts, buffer i at bits i*OCC_W |
| gnt_o | output | N | One-hot read grant, registered |
| vld_o | output | 1 | A grant is issued this slot |

## Verification
The hardest behaviour to reach from the ports is the random tie-break. The pseudo-random rotation cannot be seen or seeded from outside, so no single slot has a predictable winner. The bench holds four equal occupancies for many slots. In each slot it checks only that the winner is one of the tied buffers, and at the end it checks that more than one index has won. The rotating pointer is also hidden state: the bench reads it out by applying an all-flagged pattern in rotating mode after runs of idle slots and after longest-occupancy grants.

// File: rtl/xoa_pkg.sv
package xoa_pkg;

    typedef enum logic {
        POL_LONGEST = 1'b0,
        POL_ROTATE  = 1'b1
    } pol_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/xoa_lfsr.sv
module xoa_lfsr #(
    parameter int          W    = 8,
    parameter logic [W-1:0] TAPS = 8'hB8,
    parameter logic [W-1:0] SEED = 8'h5A
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] q_o
);

    logic [W-1:0] q_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= SEED;
        end else begin
            q_q <= {1'b0, q_q[W-1:1]} ^ (q_q[0] ? TAPS : '0);
        end
    end

    assign q_o = q_q;

    // R7
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_q != '0);

endmodule

// File: rtl/xoa_first_pick.sv
module xoa_first_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req_i,
    input  logic [IDX_W-1:0] start_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);

    int j;

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        j       = 0;
        for (int k = 0; k < N; k++) begin
            j = int'(start_i) + k;
            if (j >= N) j = j - N;
            if (!found_o && req_i[j]) begin
                found_o = 1'b1;
                idx_o   = j[IDX_W-1:0];
            end
        end
    end

endmodule

// File: rtl/xoa_max_pick.sv
module xoa_max_pick #(
    parameter int N     = 4,
    parameter int OCC_W = 3,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]       req_i,
    input  logic [N*OCC_W-1:0] occ_i,
    input  logic [IDX_W-1:0]   start_i,
    output logic               found_o,
    output logic [IDX_W-1:0]   idx_o
);

    int             j;
    logic [OCC_W-1:0] best;
    logic [OCC_W-1:0] cur;

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        best    = '0;
        cur     = '0;
        j       = 0;
        for (int k = 0; k < N; k++) begin
            j = int'(start_i) + k;
            if (j >= N) j = j - N;
            cur = occ_i[j*OCC_W +: OCC_W];
            if (req_i[j] && (!found_o || cur > best)) begin
                found_o = 1'b1;
                idx_o   = j[IDX_W-1:0];
                best    = cur;
            end
        end
    end

    // R6
    max_found_chk: assert final (found_o == (|req_i));

endmodule

// File: rtl/xbar_out_arbiter.sv
module xbar_out_arbiter
    import xoa_pkg::*;
#(
    parameter int N      = 4,
    parameter int OCC_W  = 3,
    parameter int LFSR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode_i,
    input  logic [N-1:0]       nonempty_i,
    input  logic [N*OCC_W-1:0] occ_i,
    output logic [N-1:0]       gnt_o,
    output logic               vld_o
);

    localparam int               IDX_W    = idx_width(N);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);
    localparam logic [N-1:0]     ONE_HOT0 = N'(1);

    pol_e             state_q, state_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;
    logic [N-1:0]     gnt_q, gnt_d;
    logic             vld_q, vld_d;

    logic [LFSR_W-1:0] rnd;
    logic [IDX_W-1:0]  rot_start;
    int                rot_tmp;

    logic             rr_found, mx_found, sel_found;
    logic [IDX_W-1:0] rr_idx, mx_idx, sel_idx;

    xoa_lfsr #(.W(LFSR_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .q_o   (rnd)
    );

    always_comb begin
        rot_tmp   = int'(rnd) % N;
        rot_start = rot_tmp[IDX_W-1:0];
    end

    xoa_first_pick #(.N(N), .IDX_W(IDX_W)) u_rr (
        .req_i   (nonempty_i),
        .start_i (ptr_q),
        .found_o (rr_found),
        .idx_o   (rr_idx)
    );

    xoa_max_pick #(.N(N), .OCC_W(OCC_W), .IDX_W(IDX_W)) u_max (
        .req_i   (nonempty_i),
        .occ_i   (occ_i),
        .start_i (rot_start),
        .found_o (mx_found),
        .idx_o   (mx_idx)
    );

    // policy state transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            POL_LONGEST: if (mode_i)  state_d = POL_ROTATE;   // TO_ROTATE
            POL_ROTATE:  if (!mode_i) state_d = POL_LONGEST;  // TO_LONGEST
            default:     state_d = POL_LONGEST;
        endcase
    end

    // decision outputs per state
    always_comb begin
        sel_found = 1'b0;
        sel_idx   = '0;
        unique case (state_q)
            POL_LONGEST: begin
                sel_found = mx_found;
                sel_idx   = mx_idx;
            end
            POL_ROTATE: begin
                sel_found = rr_found;
                sel_idx   = rr_idx;
            end
            default: begin
                sel_found = 1'b0;
                sel_idx   = '0;
            end
        endcase
        vld_d = sel_found;
        gnt_d = sel_found ? (ONE_HOT0 << sel_idx) : '0;
        ptr_d = ptr_q;
        if (sel_found) begin
            ptr_d = (sel_idx == LAST_IDX) ? '0 : sel_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= POL_LONGEST;
            ptr_q   <= '0;
            gnt_q   <= '0;
            vld_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            gnt_q   <= gnt_d;
            vld_q   <= vld_d;
        end
    end

    assign gnt_o = gnt_q;
    assign vld_o = vld_q;

    // R3
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o) && (vld_o == (gnt_o != '0)));

    // R4
    work_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|nonempty_i) |=> vld_o);

    // R4
    no_idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|nonempty_i) |=> !vld_o);

    // R5
    grant_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|nonempty_i) |=> (gnt_o & ~$past(nonempty_i)) == '0);

    // R9
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|nonempty_i) |=> $stable(ptr_q));

endmodule

// File: tb/xbar_out_arbiter_tb.sv
`timescale 1ns/1ps
module xbar_out_arbiter_tb;

    localparam int N = 4;
    localparam int W = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           mode_i = 1'b0;
    logic [N-1:0]   nonempty_i = '0;
    logic [N*W-1:0] occ_i = '0;
    logic [N-1:0]   gnt_o;
    logic           vld_o;

    int checks = 0;
    int errors = 0;
    int ptr_m  = 0;
    logic pol_m = 1'b0;
    bit done = 0;

    always #10 clk = ~clk;

    xbar_out_arbiter #(.N(N), .OCC_W(W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .nonempty_i (nonempty_i),
        .occ_i      (occ_i),
        .gnt_o      (gnt_o),
        .vld_o      (vld_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [N*W-1:0] pk(input int a, input int b, input int c, input int d);
        return {W'(d), W'(c), W'(b), W'(a)};
    endfunction

    function automatic int oh2i(input logic [N-1:0] g);
        for (int i = 0; i < N; i++) if (g[i]) return i;
        return -1;
    endfunction

    // one slot: apply status, sample after the edge, run generic checks
    task automatic step(input logic [N-1:0] ne, input logic [N*W-1:0] oc, input logic md,
                        output int gi);
        int exp_i;
        int mx;
        @(negedge clk);
        nonempty_i = ne; occ_i = oc; mode_i = md;
        @(posedge clk);
        #1;
        gi = oh2i(gnt_o);
        chk($onehot0(gnt_o) && (vld_o == (gnt_o != '0)), "R3 onehot/valid", int'(gnt_o), gi < 0 ? 0 : (1 << gi));
        chk(vld_o == (|ne), "R4 work-conserving", int'(vld_o), int'(|ne));
        if (gi >= 0) chk(ne[gi], "R5 grant to flagged", gi, -1);
        if (|ne) begin
            if (pol_m) begin
                exp_i = -1;
                for (int k = 0; k < N; k++)
                    if (exp_i < 0 && ne[(ptr_m + k) % N]) exp_i = (ptr_m + k) % N;
                chk(gi == exp_i, "R8 rotating pick", gi, exp_i);
            end else begin
                mx = -1;
                for (int i = 0; i < N; i++)
                    if (ne[i] && int'(oc[i*W +: W]) > mx) mx = int'(oc[i*W +: W]);
                chk(gi >= 0 && int'(oc[gi*W +: W]) == mx, "R6 longest pick",
                    gi >= 0 ? int'(oc[gi*W +: W]) : -1, mx);
            end
            if (gi >= 0) ptr_m = (gi + 1) % N;
        end
        pol_m = md;
    endtask

    task automatic t_reset();
        int g;
        chk(gnt_o == '0 && vld_o == 1'b0, "R1 reset outputs", int'(gnt_o), 0);
        step('0, '0, 1'b1, g);
        chk(g == -1, "R1 idle after reset", g, -1);
        step(4'b1111, pk(1,1,1,1), 1'b1, g);
        chk(g == 0, "R1 pointer starts at 0", g, 0);
    endtask

    task automatic t_rr_rotate();
        int g;
        for (int s = 0; s < 4; s++) begin
            step(4'b1111, pk(0,0,0,0), 1'b1, g);
            chk(g == (s + 1) % 4, "R9 pointer advances", g, (s + 1) % 4);
        end
    endtask

    task automatic t_rr_sparse();
        int g;
        step(4'b1010, pk(7,0,7,0), 1'b1, g);
        chk(g == 1, "R8 skip unflagged", g, 1);
        step(4'b1010, pk(7,0,7,0), 1'b1, g);
        chk(g == 3, "R8 next flagged", g, 3);
        step(4'b1010, pk(7,0,7,0), 1'b1, g);
        chk(g == 1, "R8 wrap", g, 1);
    endtask

    task automatic t_ptr_hold();
        int g;
        for (int s = 0; s < 3; s++) step('0, pk(7,7,7,7), 1'b1, g);
        step(4'b1111, pk(0,0,0,0), 1'b1, g);
        chk(g == 2, "R9 idle keeps pointer", g, 2);
    endtask

    task automatic t_latency();
        int g;
        step(4'b0100, pk(0,0,2,0), 1'b1, g);
        chk(g == 2, "R2 grant from sampled status", g, 2);
        step('0, '0, 1'b1, g);
        chk(vld_o == 1'b0, "R2 valid drops next slot", int'(vld_o), 0);
    endtask

    task automatic t_longest();
        int g;
        step('0, '0, 1'b0, g);
        step(4'b1111, pk(1,6,3,2), 1'b0, g);
        chk(g == 1, "R6 largest occupancy", g, 1);
        step(4'b1111, pk(4,0,5,7), 1'b0, g);
        chk(g == 3, "R6 largest at top index", g, 3);
        step(4'b1110, pk(7,2,5,1), 1'b0, g);
        chk(g == 2, "R5 unflagged occupancy ignored", g, 2);
    endtask

    task automatic t_ptr_longest();
        int g;
        step(4'b0001, pk(3,0,0,0), 1'b0, g);
        chk(g == 0, "R6 single flagged", g, 0);
        step('0, '0, 1'b1, g);
        step(4'b1111, pk(0,0,0,0), 1'b1, g);
        chk(g == 1, "R9 pointer moved by longest grant", g, 1);
    endtask

    task automatic t_ties();
        int g;
        bit [N-1:0] seen = '0;
        step('0, '0, 1'b0, g);
        for (int s = 0; s < 64; s++) begin
            step(4'b1111, pk(5,5,5,5), 1'b0, g);
            if (g >= 0) seen[g] = 1'b1;
        end
        chk($countones(seen) >= 2, "R7 tie winners vary", $countones(seen), 2);
    endtask

    task automatic t_mode();
        int g;
        int p;
        // now in longest; request rotating together with a pattern where policies differ
        p = ptr_m;
        step(4'b1111, pk(0,0,0,0) | pk(p == 3 ? 0 : 0, 0, 0, 0) | pk(0,0,0,0), 1'b0, g);
        p = ptr_m;
        step(4'b1111, pk((p+3)%4==0?6:1, (p+3)%4==1?6:1, (p+3)%4==2?6:1, (p+3)%4==3?6:1), 1'b1, g);
        chk(g == (p + 3) % 4, "R10 old policy used on change slot", g, (p + 3) % 4);
        p = ptr_m;
        step(4'b1111, pk((p+2)%4==0?6:1, (p+2)%4==1?6:1, (p+2)%4==2?6:1, (p+2)%4==3?6:1), 1'b1, g);
        chk(g == p, "R10 new policy one slot later", g, p);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_rr_rotate();
        t_rr_sparse();
        t_ptr_hold();
        t_latency();
        t_longest();
        t_ptr_longest();
        t_ties();
        t_mode();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule